// File: doc/BRIEF.md
# Low-Speed USB Bit-Stream Receiver

This block watches the two data lines of a low-speed USB bus and turns the serial stream into bytes. It runs from a clock that is a fixed multiple of the bit rate. The default is 12 clocks per bit, which gives 18 MHz sampling of a 1.5 Mbit/s bus. Both lines first pass through a synchroniser. The block then waits for a transition from the idle state J to K. It sets its sampling phase from the last such transition in the sync field and takes one sample near the centre of each bit.

Once the two closing K bits of the sync field have been seen, the block signals the start of a packet. It then decodes NRZI, removes stuffed bits and shifts the data bits into bytes, least significant bit first. Each byte is reported with a one-cycle valid pulse. A single-ended zero at a sample point ends the packet. A stuffed bit that fails to change the line aborts the packet with an error pulse. A broken sync field is dropped without any output. PID and CRC checking are left to the logic that reads the byte stream.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset all four pulse outputs are low. The synchronised line is taken to be J (D+ low, D- high), so releasing reset on an idle bus produces no activity.
- R2: Each bit is sampled once. A result caused by a bit whose level is first presented at clock edge n appears on the outputs after edge n + SYNC_STAGES + CLKS_PER_BIT/2, which is n + 8 with the defaults. The sampling phase is set from each J-to-K transition seen while hunting or in sync.
- R3: A sync sample of K that follows a sync sample of K completes the sync field. `pkt_start` pulses, and that K becomes the reference level for NRZI decoding.
- R4: Sync is abandoned silently, and hunting resumes, when any of these occurs: a J sample follows a J sample, a sample is neither J nor K (both lines low or both high), or the eighth sync sample does not complete the K-K pair. No `pkt_start` is produced in any of these cases.
- R5: While receiving, a sample equal to the previous sample decodes as 1. A sample that differs decodes as 0.
- R6: The run counter of decoded 1s starts at 1 when sync completes, because the closing K-K pair counts as a 1. After six consecutive 1s, the next bit is a stuffed bit. When it toggles the line, it is discarded and the run counter clears.
- R7: A stuffed bit that leaves the line unchanged raises `stuff_err` for one cycle. The packet is abandoned with no `pkt_end`, and no further bytes are reported.
- R8: Data bits fill bytes least significant bit first. `byte_valid` pulses for one cycle with `byte_data` in the same cycle as the eighth bit's result.
- R9: A sample with both lines low during reception pulses `pkt_end` and returns the block to hunting. Any bits of an incomplete byte are discarded.
- R10: `byte_valid`, `pkt_start`, `pkt_end` and `stuff_err` are single-cycle pulses, and no two of them are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, CLKS_PER_BIT cycles per bus bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_dp | input | 1 | Raw D+ line |
| usb_dm | input | 1 | Raw D- line |
| byte_valid | output | 1 | One-cycle pulse: byte_data holds a received byte |
| byte_data | output | BYTE_W | Received byte, first bus bit in bit 0 |
| pkt_start | output | 1 | One-cycle pulse when the sync field completes |
| pkt_end | output | 1 | One-cycle pulse when a single-ended zero ends the packet |
| stuff_err | output | 1 | One-cycle pulse when a stuffed bit does not toggle the line |

## Verification
Every output pulse is the result of one bit sample, and it appears 8 cycles after the clock edge at which that bit's level first reaches the pins. The sync completion is due at 12·7+8 = 92 cycles after the first sync bit. A byte is due at 12·w+8 cycles, where w is the wire index of its last bit with stuffed bits included. The bench counts wire bits while it encodes, so it knows the due cycle for each event. It stamps every observed pulse with a free-running cycle count taken at the falling edge and compares the stamp with the due cycle exactly. Any drift in the pipeline depth or in the phase lock therefore shows up as a timing mismatch, and not only as a wrong byte.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

   // Line symbol as {D+, D-}
   typedef enum logic [1:0] {
      LN_SE0 = 2'b00,
      LN_J   = 2'b01,
      LN_K   = 2'b10,
      LN_SE1 = 2'b11
   } line_e;

   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_SYNC = 2'd1,
      ST_RECV = 2'd2
   } rx_st_e;

endpackage

// File: rtl/usb_ls_rx_sync.sv
module usb_ls_rx_sync #(
   parameter int          STAGES  = 2,
   parameter logic [1:0]  RST_VAL = 2'b01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] d,
   output logic [1:0] q
);
   logic [STAGES-1:0][1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/usb_ls_rx_phase.sv
module usb_ls_rx_phase #(
   parameter int CLKS_PER_BIT = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic relock,
   output logic strobe
);
   localparam int            CW   = $clog2(CLKS_PER_BIT);
   localparam logic [CW-1:0] MID  = CW'(CLKS_PER_BIT / 2);
   localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (relock)      cnt <= CW'(1);
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + CW'(1);
   end

   assign strobe = (cnt == MID);

   // R2: one sample per bit, never two in a row
   p_strobe_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);
endmodule

// File: rtl/usb_ls_rx_dec.sv
module usb_ls_rx_dec #(
   parameter int BYTE_W    = 8,
   parameter int STUFF_RUN = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              bit_en,
   input  logic              bit_val,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_data,
   output logic              stuff_fault
);
   localparam int            RW   = $clog2(STUFF_RUN + 1);
   localparam int            BW   = $clog2(BYTE_W);
   localparam logic [RW-1:0] RUN  = RW'(STUFF_RUN);
   localparam logic [BW-1:0] BLST = BW'(BYTE_W - 1);

   logic [RW-1:0]     ones;
   logic [BW-1:0]     bcnt;
   logic [BYTE_W-1:0] sr;
   logic              stuff_slot;
   logic [BYTE_W-1:0] sr_next;

   assign stuff_slot  = (ones == RUN);
   assign stuff_fault = bit_en && stuff_slot && bit_val;
   assign sr_next     = {bit_val, sr[BYTE_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones       <= '0;
         bcnt       <= '0;
         sr         <= '0;
         byte_valid <= 1'b0;
         byte_data  <= '0;
      end else begin
         byte_valid <= 1'b0;
         if (init) begin
            ones <= RW'(1);
            bcnt <= '0;
         end else if (bit_en) begin
            if (stuff_slot) begin
               ones <= '0;
            end else begin
               ones <= bit_val ? ones + RW'(1) : '0;
               sr   <= sr_next;
               bcnt <= (bcnt == BLST) ? '0 : bcnt + BW'(1);
               if (bcnt == BLST) begin
                  byte_valid <= 1'b1;
                  byte_data  <= sr_next;
               end
            end
         end
      end
   end

   // R6: the run of ones never passes the stuffing limit
   p_run_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ones <= RUN);
   // R8: a byte only follows an accepted bit sample
   p_byte_on_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> $past(bit_en));
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
   import usb_ls_rx_pkg::*;
#(
   parameter int CLKS_PER_BIT = 12,
   parameter int SYNC_STAGES  = 2,
   parameter int BYTE_W       = 8,
   parameter int STUFF_RUN    = 6,
   parameter int SYNC_BITS    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              usb_dp,
   input  logic              usb_dm,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_data,
   output logic              pkt_start,
   output logic              pkt_end,
   output logic              stuff_err
);
   localparam int            SW        = $clog2(SYNC_BITS);
   localparam logic [SW-1:0] SYNC_LAST = SW'(SYNC_BITS - 1);

   generate
      if (CLKS_PER_BIT < 4) begin : g_bad_cpb
         $error("CLKS_PER_BIT must be at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (STUFF_RUN < 1 || SYNC_BITS < 2) begin : g_bad_proto
         $error("STUFF_RUN and SYNC_BITS out of range");
      end
   endgenerate

   logic [1:0]    sync_q;
   line_e         line_s, line_q, prev_sym, last_sym;
   rx_st_e        st;
   logic [SW-1:0] sync_idx;
   logic          edge_jk, relock, strobe, sync_done, bit_en, bit_val, stuff_fault;

   usb_ls_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LN_J)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({usb_dp, usb_dm}), .q(sync_q));

   assign line_s  = line_e'(sync_q);
   assign edge_jk = (line_q == LN_J) && (line_s == LN_K);
   assign relock  = edge_jk && (st != ST_RECV);

   usb_ls_rx_phase #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_phase (
      .clk(clk), .rst_n(rst_n), .relock(relock), .strobe(strobe));

   assign sync_done = (st == ST_SYNC) && strobe && (line_s == LN_K) && (prev_sym == LN_K);
   assign bit_en    = (st == ST_RECV) && strobe && (line_s != LN_SE0);
   assign bit_val   = (line_s == last_sym);

   usb_ls_rx_dec #(.BYTE_W(BYTE_W), .STUFF_RUN(STUFF_RUN)) u_dec (
      .clk(clk), .rst_n(rst_n), .init(sync_done), .bit_en(bit_en), .bit_val(bit_val),
      .byte_valid(byte_valid), .byte_data(byte_data), .stuff_fault(stuff_fault));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_HUNT;
         line_q    <= LN_J;
         prev_sym  <= LN_J;
         last_sym  <= LN_J;
         sync_idx  <= '0;
         pkt_start <= 1'b0;
         pkt_end   <= 1'b0;
         stuff_err <= 1'b0;
      end else begin
         line_q    <= line_s;
         pkt_start <= 1'b0;
         pkt_end   <= 1'b0;
         stuff_err <= 1'b0;
         unique case (st)
            ST_HUNT: begin
               if (edge_jk) begin
                  st       <= ST_SYNC;
                  prev_sym <= LN_J;
                  sync_idx <= '0;
               end
            end
            ST_SYNC: begin
               if (strobe) begin
                  sync_idx <= sync_idx + SW'(1);
                  if (sync_done) begin
                     st        <= ST_RECV;
                     pkt_start <= 1'b1;
                     last_sym  <= LN_K;
                  end else if (sync_idx == SYNC_LAST) begin
                     st <= ST_HUNT;
                  end else if (line_s == LN_K || (line_s == LN_J && prev_sym == LN_K)) begin
                     prev_sym <= line_s;
                  end else begin
                     st <= ST_HUNT;
                  end
               end
            end
            ST_RECV: begin
               if (strobe) begin
                  if (line_s == LN_SE0) begin
                     pkt_end <= 1'b1;
                     st      <= ST_HUNT;
                  end else begin
                     last_sym <= line_s;
                     if (stuff_fault) begin
                        stuff_err <= 1'b1;
                        st        <= ST_HUNT;
                     end
                  end
               end
            end
            default: st <= ST_HUNT;
         endcase
      end
   end

   // R10: at most one event pulse per cycle
   p_one_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({byte_valid, pkt_start, pkt_end, stuff_err}));
   // R10: packet start is a single-cycle pulse
   p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start |=> !pkt_start);
   // R3: sync completes only on a sampled K
   p_start_on_k_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start |-> ($past(strobe) && $past(line_s) == LN_K));
   // R9: packet end only on a sampled single-ended zero
   p_end_on_se0_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_end |-> ($past(strobe) && $past(line_s) == LN_SE0));
   // R7: a stuff error comes from a sample that repeated the line level
   p_err_no_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stuff_err |-> $past(line_s == last_sym));
endmodule

// File: tb/sim_usb_ls_rx.sv
`timescale 1ns/1ps
module sim_usb_ls_rx;
   localparam int CPB = 12;
   localparam logic [1:0] J = 2'b01, K = 2'b10, SE0 = 2'b00;
   // {byte count, byte0, byte1, byte2}
   localparam logic [25:0] VEC [6] = '{
      {2'd1, 8'h00, 8'h00, 8'h00},
      {2'd1, 8'hFF, 8'h00, 8'h00},
      {2'd2, 8'hA5, 8'h3C, 8'h00},
      {2'd3, 8'hFF, 8'hFF, 8'hFF},
      {2'd2, 8'h7E, 8'h81, 8'h00},
      {2'd3, 8'h01, 8'hC3, 8'hF0}
   };

   logic clk = 1'b0, rst_n = 1'b0, dp = 1'b0, dm = 1'b1;
   logic       byte_valid, pkt_start, pkt_end, stuff_err;
   logic [7:0] byte_data;

   always #4 clk = ~clk;

   usb_ls_rx u0 (.clk(clk), .rst_n(rst_n), .usb_dp(dp), .usb_dm(dm),
      .byte_valid(byte_valid), .byte_data(byte_data), .pkt_start(pkt_start),
      .pkt_end(pkt_end), .stuff_err(stuff_err));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_fail = 0, n_multi = 0, n_long = 0;
   int n_rx, n_ps, n_pe, n_se, ps_c, pe_c, se_c;
   int rx_b [16];
   int rx_c [16];
   logic [3:0] prev_f = '0;
   bit finished = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (int'(byte_valid) + int'(pkt_start) + int'(pkt_end) + int'(stuff_err) > 1) n_multi++;
         if (({byte_valid, pkt_start, pkt_end, stuff_err} & prev_f) != 4'b0) n_long++;
         prev_f = {byte_valid, pkt_start, pkt_end, stuff_err};
         if (byte_valid) begin
            if (n_rx < 16) begin rx_b[n_rx] = byte_data; rx_c[n_rx] = cyc; end
            n_rx++;
         end
         if (pkt_start) begin n_ps++; ps_c = cyc; end
         if (pkt_end)   begin n_pe++; pe_c = cyc; end
         if (stuff_err) begin n_se++; se_c = cyc; end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   logic [1:0] lvl;
   int run, widx, t0;
   int exp_c [16];

   task automatic clear_mon();
      n_rx = 0; n_ps = 0; n_pe = 0; n_se = 0; ps_c = -1; pe_c = -1; se_c = -1;
   endtask

   task automatic put(input logic [1:0] v);
      {dp, dm} = v;
      widx++;
      repeat (CPB) @(negedge clk);
   endtask

   task automatic enc(input logic b);
      if (!b) begin lvl = ~lvl; run = 0; end
      else run++;
      put(lvl);
      if (run == 6) begin lvl = ~lvl; put(lvl); run = 0; end
   endtask

   task automatic start_pkt();
      clear_mon();
      put(J); put(J);
      widx = 0;
      t0 = cyc + 1;
      put(K); put(J); put(K); put(J); put(K); put(J); put(K); put(K);
      lvl = K; run = 1;
   endtask

   task automatic send_byte(input logic [7:0] b, input int k);
      for (int i = 0; i < 8; i++) begin
         if (i == 7) exp_c[k] = t0 + CPB * widx + 8;
         enc(b[i]);
      end
   endtask

   task automatic end_pkt(output int eop_c);
      eop_c = t0 + CPB * widx + 8;
      put(SE0); put(SE0); put(J); put(J); put(J);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog (R1..R10 run) actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int eop;
      clear_mon();
      repeat (5) @(negedge clk);
      chk("R1 reset byte_valid", int'(byte_valid), 0);
      chk("R1 reset pkt_start", int'(pkt_start), 0);
      chk("R1 reset pkt_end/stuff_err", int'(pkt_end) + int'(stuff_err), 0);
      rst_n = 1'b1;
      repeat (30) @(negedge clk);
      chk("R1 idle bus after reset gives no events", n_rx + n_ps + n_pe + n_se, 0);

      // Table-driven packets
      for (int v = 0; v < 6; v++) begin
         int nb;
         nb = int'(VEC[v][25:24]);
         start_pkt();
         for (int k = 0; k < nb; k++) send_byte(VEC[v][23 - 8*k -: 8], k);
         end_pkt(eop);
         chk("R3 one pkt_start", n_ps, 1);
         chk("R2 pkt_start cycle", ps_c - t0, 92);
         chk("R8 byte count", n_rx, nb);
         for (int k = 0; k < nb && k < n_rx; k++) begin
            chk("R5 R6 R8 byte value", rx_b[k], int'(VEC[v][23 - 8*k -: 8]));
            chk("R2 byte cycle", rx_c[k], exp_c[k]);
         end
         chk("R9 one pkt_end", n_pe, 1);
         chk("R9 pkt_end cycle", pe_c, eop);
         chk("R7 no stuff_err on clean stuffing", n_se, 0);
      end

      // R9: partial byte dropped at single-ended zero
      start_pkt();
      send_byte(8'hC3, 0);
      enc(1'b1); enc(1'b0); enc(1'b1);
      end_pkt(eop);
      chk("R9 partial byte discarded", n_rx, 1);
      chk("R8 byte before partial", rx_b[0], 8'hC3);
      chk("R9 pkt_end with partial", n_pe, 1);
      chk("R9 pkt_end cycle with partial", pe_c, eop);

      // R7: stuffed bit that does not toggle
      start_pkt();
      put(K); put(K); put(K); put(K); put(K);
      put(K);
      put(SE0); put(SE0); put(J); put(J); put(J);
      chk("R7 stuff_err raised", n_se, 1);
      chk("R7 stuff_err cycle", se_c - t0, CPB * 13 + 8);
      chk("R7 no pkt_end after abort", n_pe, 0);
      chk("R7 no bytes after abort", n_rx, 0);

      // R6: six ones followed by a proper stuff toggle then zero bits
      start_pkt();
      send_byte(8'h3F, 0);
      end_pkt(eop);
      chk("R6 stuffed bit removed", rx_b[0], 8'h3F);
      chk("R6 byte cycle after stuffing", rx_c[0], exp_c[0]);

      // R4: sync never closes within eight samples
      clear_mon();
      put(J); put(J);
      put(K); put(J); put(K); put(J); put(K); put(J); put(K); put(J);
      put(J); put(J); put(J);
      chk("R4 timeout no pkt_start", n_ps, 0);
      chk("R4 timeout no other events", n_rx + n_pe + n_se, 0);

      // R4: two J samples in a row
      clear_mon();
      put(K); put(J); put(J); put(J); put(J);
      chk("R4 double J no pkt_start", n_ps, 0);

      // R4: single-ended zero inside sync
      clear_mon();
      put(K); put(J); put(SE0); put(J); put(J); put(J);
      chk("R4 SE0 in sync no pkt_start", n_ps + n_pe, 0);

      // R4: recovery with a good packet afterwards
      start_pkt();
      send_byte(8'h96, 0);
      end_pkt(eop);
      chk("R4 recovery pkt_start", n_ps, 1);
      chk("R4 recovery byte", rx_b[0], 8'h96);

      chk("R10 overlapping pulses", n_multi, 0);
      chk("R10 pulses longer than one cycle", n_long, 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule